// File: doc/BRIEF.md
# Parallel ATA PIO cycle timer

This block runs single programmed-I/O transfers from the host side of a parallel ATA style device bus. A requester presents a direction, a register address, write data and a transfer mode number while the block is idle. The block then walks the bus through three phases: address setup with both strobes high, strobe active, and strobe recovery. It then pulses a completion flag. The minimum length of each phase depends on the selected mode. The active phase can be stretched by the device through the IORDY input, up to a bounded limit.

All timing minimums are held in nanoseconds. They are turned into clock counts at elaboration time from a clock-period parameter, always rounding up. A faster or slower system clock therefore needs only a new parameter value. Read data is latched when the read strobe is released and is held on a dedicated output until the next transfer is accepted.

Top module: `pio_cycle_timer`

## Requirements
- R1: Every phase length is the nanosecond minimum divided by CLK_NS and rounded up. Mode numbers 0 to 4 select their own timing set. Mode codes 5, 6 and 7 use the mode 0 (slowest) set.
- R2: After a request is accepted, the address is driven with both strobes high for the setup count (ns: 70/50/30/30/25 for modes 0..4). The address stays stable until completion.
- R3: The strobe stays low for at least the active count, which is the larger of the strobe-width minimum (165/125/100/80/70 ns) and the write data setup minimum (60/45/30/30/20 ns).
- R4: After the strobe rises, the bus stays in recovery for max(base, cycle - active_actual) clocks. The base on writes is the largest of the recovery (-/-/-/70/25 ns), data hold (30/20/15/10/10 ns) and address hold (20/15/10/10/10 ns) minimums. On reads, the data hold term is replaced by a 30 ns bus-release time. The cycle minimum is 600/383/240/180/120 ns, counted from strobe assertion.
- R5: On a write (req_write_i=1), ata_oe_o is high and ata_dout_o carries the write data from acceptance until completion. ata_wr_no is the only strobe that goes low.
- R6: IORDY is evaluated from the 35 ns sample point onward. If the active minimum has elapsed but ata_iordy_i is low, the strobe stays low until the first clock in which ata_iordy_i is high.
- R7: If ata_iordy_i is still low once the strobe has been low for the sample count plus the 1250 ns limit, the strobe is released. timeout_o is then high in the same cycle as done_o.
- R8: On a read, ata_din_i is latched into rd_data_o on the clock edge that releases ata_rd_no. rd_data_o does not change again until the next read strobe.
- R9: ata_oe_o is low for the whole of a read and for its recovery. The two strobes are never low together.
- R10: req_valid_i is ignored while a transfer is in progress. The bus address and the strobes are unaffected, and no extra transfer follows.
- R11: After reset, both strobes are high, ata_oe_o, done_o and timeout_o are low and rd_data_o is zero. done_o is high for exactly one clock per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a transfer (taken only when idle) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Device register address |
| req_wdata_i | input | DATA_W | Write data |
| req_mode_i | input | 3 | Transfer mode 0..4 (5..7 act as 0) |
| ata_addr_o | output | ADDR_W | Bus address |
| ata_rd_no | output | 1 | Read strobe, active low |
| ata_wr_no | output | 1 | Write strobe, active low |
| ata_oe_o | output | 1 | Data bus output enable |
| ata_dout_o | output | DATA_W | Data driven onto the bus |
| ata_din_i | input | DATA_W | Data from the bus |
| ata_iordy_i | input | 1 | Device ready, high = ready |
| rd_data_o | output | DATA_W | Last captured read data |
| done_o | output | 1 | One-clock completion pulse |
| timeout_o | output | 1 | IORDY limit exceeded, valid with done_o |

## Verification
Reads and writes are run in every mode, with the ready line held high, so that the measured setup, strobe and recovery lengths pin down each mode's entry in the count table. An out-of-range mode code is used to show the clamp to the slowest set. The ready line is also released before the active minimum, which must have no effect, and after the minimum, which must stretch the strobe exactly to the release point. It is never released in one case, so the timeout length and flag can be measured. A request raised in the middle of a transfer shows that the bus ignores it, and changing the bus data after the read strobe rises shows that the captured value holds.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NUM_MODES = 5;
  localparam int MODE_W = 3;
  localparam int CNT_W = 12;
  localparam int IORDY_SAMPLE_NS = 35;
  localparam int IORDY_LIMIT_NS = 1250;
  localparam int RD_RELEASE_NS = 30;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACTIVE, ST_RECOV} pio_state_e;

  typedef enum int {K_CYCLE, K_SETUP, K_ACTIVE, K_RECOV, K_WSETUP, K_WHOLD, K_AHOLD} pio_kind_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] recov;
    logic [CNT_W-1:0] cycle;
    logic [CNT_W-1:0] sample;
    logic [CNT_W-1:0] limit;
  } pio_timing_t;

  function automatic int ceil_div(int ns, int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int mode_ns(pio_kind_e k, int m);
    int t[NUM_MODES];
    case (k)
      K_CYCLE:  t = '{600, 383, 240, 180, 120};
      K_SETUP:  t = '{70, 50, 30, 30, 25};
      K_ACTIVE: t = '{165, 125, 100, 80, 70};
      K_RECOV:  t = '{0, 0, 0, 70, 25};
      K_WSETUP: t = '{60, 45, 30, 30, 20};
      K_WHOLD:  t = '{30, 20, 15, 10, 10};
      default:  t = '{20, 15, 10, 10, 10};
    endcase
    return t[m];
  endfunction

  function automatic int active_clk(int m, int per);
    return max2(ceil_div(mode_ns(K_ACTIVE, m), per), ceil_div(mode_ns(K_WSETUP, m), per));
  endfunction

  function automatic int min_active_clk(int per);
    int r;
    r = active_clk(0, per);
    for (int m = 1; m < NUM_MODES; m++) r = (active_clk(m, per) < r) ? active_clk(m, per) : r;
    return r;
  endfunction
endpackage

// File: rtl/pio_mode_timing.sv
module pio_mode_timing
  import pio_pkg::*;
#(
  parameter int CLK_NS = 8
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              write_i,
  output pio_timing_t       tim_o
);
  localparam logic [MODE_W-1:0] LAST_MODE = MODE_W'(NUM_MODES - 1);
  localparam int SAMPLE_CLK = ceil_div(IORDY_SAMPLE_NS, CLK_NS);
  localparam int LIMIT_CLK = SAMPLE_CLK + ceil_div(IORDY_LIMIT_NS, CLK_NS);

  logic [CNT_W-1:0] setup_tab [NUM_MODES];
  logic [CNT_W-1:0] active_tab[NUM_MODES];
  logic [CNT_W-1:0] rec_wr_tab[NUM_MODES];
  logic [CNT_W-1:0] rec_rd_tab[NUM_MODES];
  logic [CNT_W-1:0] cycle_tab [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int REC = ceil_div(mode_ns(K_RECOV, m), CLK_NS);
    localparam int AHOLD = ceil_div(mode_ns(K_AHOLD, m), CLK_NS);
    localparam int WHOLD = ceil_div(mode_ns(K_WHOLD, m), CLK_NS);
    localparam int RREL = ceil_div(RD_RELEASE_NS, CLK_NS);
    assign setup_tab[m]  = CNT_W'(ceil_div(mode_ns(K_SETUP, m), CLK_NS));
    assign active_tab[m] = CNT_W'(active_clk(m, CLK_NS));
    assign rec_wr_tab[m] = CNT_W'(max2(REC, max2(WHOLD, AHOLD)));
    assign rec_rd_tab[m] = CNT_W'(max2(REC, max2(RREL, AHOLD)));
    assign cycle_tab[m]  = CNT_W'(ceil_div(mode_ns(K_CYCLE, m), CLK_NS));
  end

  logic [MODE_W-1:0] idx;
  assign idx = (mode_i > LAST_MODE) ? '0 : mode_i;  // out-of-range codes fall back to slowest

  always_comb begin
    tim_o.setup  = setup_tab[idx];
    tim_o.active = active_tab[idx];
    tim_o.recov  = write_i ? rec_wr_tab[idx] : rec_rd_tab[idx];
    tim_o.cycle  = cycle_tab[idx];
    tim_o.sample = CNT_W'(SAMPLE_CLK);
    tim_o.limit  = CNT_W'(LIMIT_CLK);
  end
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [MODE_W-1:0] req_mode_i,
  input  pio_timing_t       tim_i,
  input  logic              iordy_i,
  input  logic [DATA_W-1:0] din_i,
  output pio_state_e        state_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              timeout_o
);
  pio_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q, tot_q;
  logic [MODE_W-1:0] mode_q;
  logic              write_q, done_q, to_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              ready_hit, expired, rec_met;

  assign ready_hit = iordy_i && (cnt_q >= tim_i.active) && (cnt_q >= tim_i.sample);
  assign expired   = !iordy_i && (cnt_q >= tim_i.limit);
  assign rec_met   = (cnt_q >= tim_i.recov) && (tot_q >= tim_i.cycle);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tot_q   <= '0;
      mode_q  <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q <= ST_SETUP;
          cnt_q   <= CNT_W'(1);
          mode_q  <= req_mode_i;
          write_q <= req_write_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          to_q    <= 1'b0;
        end
        ST_SETUP: begin
          if (cnt_q >= tim_i.setup) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= CNT_W'(1);
            tot_q   <= CNT_W'(1);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ACTIVE: begin
          tot_q <= tot_q + 1'b1;
          if (ready_hit || expired) begin
            state_q <= ST_RECOV;
            cnt_q   <= CNT_W'(1);
            to_q    <= expired;
            if (!write_q) rdata_q <= din_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (rec_met) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            tot_q <= tot_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign state_o   = state_q;
  assign mode_o    = mode_q;
  assign write_o   = write_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign rdata_o   = rdata_q;
  assign done_o    = done_q;
  assign timeout_o = done_q & to_q;
endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_pkg::*;
#(
  parameter int CLK_NS = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [2:0]        req_mode_i,
  output logic [ADDR_W-1:0] ata_addr_o,
  output logic              ata_rd_no,
  output logic              ata_wr_no,
  output logic              ata_oe_o,
  output logic [DATA_W-1:0] ata_dout_o,
  input  logic [DATA_W-1:0] ata_din_i,
  input  logic              ata_iordy_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o,
  output logic              timeout_o
);
  pio_timing_t       tim;
  pio_state_e        state;
  logic [MODE_W-1:0] mode_q;
  logic              write_q;

  pio_mode_timing #(.CLK_NS(CLK_NS)) u_timing (
    .mode_i (mode_q),
    .write_i(write_q),
    .tim_o  (tim)
  );

  pio_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .req_mode_i (req_mode_i),
    .tim_i      (tim),
    .iordy_i    (ata_iordy_i),
    .din_i      (ata_din_i),
    .state_o    (state),
    .mode_o     (mode_q),
    .write_o    (write_q),
    .addr_o     (ata_addr_o),
    .wdata_o    (ata_dout_o),
    .rdata_o    (rd_data_o),
    .done_o     (done_o),
    .timeout_o  (timeout_o)
  );

  assign ata_rd_no = !((state == ST_ACTIVE) && !write_q);
  assign ata_wr_no = !((state == ST_ACTIVE) && write_q);
  assign ata_oe_o  = write_q && (state != ST_IDLE);
endmodule

// File: rtl/pio_cycle_timer_chk.sv
module pio_cycle_timer_chk
  import pio_pkg::*;
#(
  parameter int CLK_NS = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] ata_addr_o,
  input logic              ata_rd_no,
  input logic              ata_wr_no,
  input logic              ata_oe_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              done_o,
  input logic              timeout_o
);
  localparam int MIN_ACT = min_active_clk(CLK_NS);

  logic             strobe_any;
  logic [CNT_W-1:0] low_cnt;

  assign strobe_any = !(ata_rd_no && ata_wr_no);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_cnt <= '0;
    else if (strobe_any) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ata_rd_no && !ata_wr_no));  // R9
  AST_NO_OE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ata_rd_no |-> !ata_oe_o);  // R9
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_any |-> $stable(ata_addr_o));  // R2
  AST_MIN_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_any) |-> (low_cnt >= CNT_W'(MIN_ACT)));  // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R11
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o != $past(rd_data_o)) |-> !$past(ata_rd_no));  // R8
  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);  // R7
endmodule

bind pio_cycle_timer pio_cycle_timer_chk #(.CLK_NS(CLK_NS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_pio_cycle_timer.sv
module sim_pio_cycle_timer;
  localparam int PER = 8;
  localparam int AW = 4;
  localparam int DW = 16;

  localparam int T0[5]  = '{600, 383, 240, 180, 120};
  localparam int T1[5]  = '{70, 50, 30, 30, 25};
  localparam int T2[5]  = '{165, 125, 100, 80, 70};
  localparam int T2I[5] = '{0, 0, 0, 70, 25};
  localparam int T3[5]  = '{60, 45, 30, 30, 20};
  localparam int T4[5]  = '{30, 20, 15, 10, 10};
  localparam int T9[5]  = '{20, 15, 10, 10, 10};

  typedef struct packed {
    logic          wr;
    logic [2:0]    mode;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } vec_t;

  localparam vec_t VEC[8] = '{
    '{1'b1, 3'd0, 4'h3, 16'h1234},
    '{1'b0, 3'd1, 4'h5, 16'hA001},
    '{1'b1, 3'd2, 4'h7, 16'h5AA5},
    '{1'b0, 3'd3, 4'h1, 16'hA003},
    '{1'b1, 3'd4, 4'hE, 16'hFFFF},
    '{1'b0, 3'd4, 4'h2, 16'hA005},
    '{1'b1, 3'd3, 4'h9, 16'h0F0F},
    '{1'b0, 3'd7, 4'h6, 16'hA007}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, iordy = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, din = '0;
  logic [2:0] req_mode = '0;
  logic [AW-1:0] addr;
  logic rd_n, wr_n, oe, done, tmo;
  logic [DW-1:0] dout, rdata;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(PER / 2) clk = ~clk;

  pio_cycle_timer #(.CLK_NS(PER), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_mode_i(req_mode),
    .ata_addr_o(addr), .ata_rd_no(rd_n), .ata_wr_no(wr_n), .ata_oe_o(oe),
    .ata_dout_o(dout), .ata_din_i(din), .ata_iordy_i(iordy), .rd_data_o(rdata),
    .done_o(done), .timeout_o(tmo)
  );

  function automatic int cd(int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int mx(int a, int b);
    return a > b ? a : b;
  endfunction
  function automatic int eff(int m);
    return m > 4 ? 0 : m;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // iordy_at: 0 = ready throughout, >0 = raised at that strobe-low sample, -1 = never
  task automatic run(bit wr, int mode, logic [AW-1:0] a, logic [DW-1:0] d, int iordy_at, bit poke);
    int m, s, act, rec, exp_a, exp_r, guard, bad;
    logic [DW-1:0] rd_exp;
    m = eff(mode);
    exp_a = (iordy_at < 0) ? cd(35) + cd(1250) : mx(mx(cd(T2[m]), cd(T3[m])), iordy_at);
    exp_r = mx(wr ? mx(cd(T2I[m]), mx(cd(T4[m]), cd(T9[m])))
                  : mx(cd(T2I[m]), mx(cd(30), cd(T9[m]))), cd(T0[m]) - exp_a);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mode = 3'(mode);
    din = d; rd_exp = d;
    iordy = (iordy_at == 0);
    @(negedge clk);
    req_valid = 1'b0;
    s = 0; act = 0; rec = 0; bad = 0; guard = 0;
    while (rd_n && wr_n && guard < 2000) begin
      s++; guard++;
      if (addr !== a || oe !== wr) bad++;
      @(negedge clk);
    end
    while (!(rd_n && wr_n) && guard < 2000) begin
      act++; guard++;
      if (addr !== a || oe !== wr || rd_n !== wr || wr_n !== !wr) bad++;
      if (wr && dout !== d) bad++;
      if (poke && act == 2) begin req_valid = 1'b1; req_addr = ~a; end
      if (poke && act == 3) req_valid = 1'b0;
      if (act == iordy_at) iordy = 1'b1;
      @(negedge clk);
    end
    din = ~d;
    while (!done && guard < 2000) begin
      rec++; guard++;
      if (addr !== a || oe !== wr || !rd_n || !wr_n) bad++;
      @(negedge clk);
    end
    chk(s == cd(T1[m]), "R2 setup cycles", s, cd(T1[m]));
    if (iordy_at > 0) chk(act == exp_a, "R6 stretched strobe", act, exp_a);
    else if (iordy_at < 0) chk(act == exp_a, "R7 timeout strobe length", act, exp_a);
    else if (mode > 4) chk(act == exp_a, "R1 clamped mode strobe", act, exp_a);
    else chk(act == exp_a, "R3 strobe active cycles", act, exp_a);
    chk(rec == exp_r, "R4 recovery cycles", rec, exp_r);
    chk(bad == 0, wr ? "R5 write bus hold" : "R9 read bus idle", bad, 0);
    chk(tmo == (iordy_at < 0), "R7 timeout flag", int'(tmo), int'(iordy_at < 0));
    if (!wr) chk(rdata == rd_exp, "R8 read capture", int'(rdata), int'(rd_exp));
    @(negedge clk);
    chk(!done, "R11 done one clock", int'(done), 0);
    iordy = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_n && wr_n && !oe && !done && !tmo && rdata == '0, "R11 reset state", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) run(VEC[i].wr, int'(VEC[i].mode), VEC[i].addr, VEC[i].data, 0, 0);
    // R6: ready released before the minimum has no effect, after it stretches
    run(1'b1, 4, 4'hA, 16'h2222, 3, 0);
    run(1'b1, 4, 4'hB, 16'h3333, 30, 0);
    // R7: never ready
    run(1'b0, 4, 4'hC, 16'hBEEF, -1, 0);
    // R10: request during a transfer is ignored
    run(1'b0, 2, 4'h4, 16'hC0DE, 0, 1);
    begin
      int bad = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (!rd_n || !wr_n || done || addr !== 4'h4) bad++;
      end
      chk(bad == 0, "R10 busy request ignored", bad, 0);
    end
    // R8: read data held across idle time
    chk(rdata == 16'hC0DE, "R8 read data stable", int'(rdata), 16'hC0DE);
    summary();
    $finish;
  end
endmodule